// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register File

This block holds the host-visible control state of a two-channel bus-master disk DMA controller. Each channel has three registers: a command register that starts and stops transfers and selects the transfer direction, a status register with an active flag and two engine-reported event flags, and a pointer to the channel's descriptor table in memory. The host reaches them through a small byte-addressed register bus whose write strobe carries a transfer size. Reads are combinational from the address.

The block enforces each register's access rules. It turns run-bit edges into one-cycle start and stop requests toward a DMA engine, and it keeps the active flag in step with those requests. It rejects writes of the wrong size and reports them, together with refused start attempts, on a one-cycle error pulse. The DMA engine reports errors and interrupts through per-channel set pulses. The host clears those flags by writing ones.

Address map: bit 3 of the address selects the channel. Bits 2:0 select the register: 0 is the command register, 2 is the status register and 4 is the descriptor pointer. Write data is right-justified on `bus_wdata`. Size codes are 0 for one byte, 1 for two bytes, 2 for four bytes, and 3, which no register accepts. Command bits: bit 0 run, bit 3 direction. Status bits: bit 0 active, bit 1 error, bit 2 interrupt, bits 6:5 host scratch flags.

Top module: `bmdma_regs`

## Requirements
- R1: After reset all registers read zero and `start_req`, `stop_req`, `bus_err`, `chan_active` and `chan_dir` are zero.
- R2: Address bit 3 selects the channel; a write to one channel leaves the other channel's registers unchanged.
- R3: A command write that sets the run bit (bit 0) while it was clear, with that channel's `drive_present` high, makes `start_req` for that channel high for exactly the cycle after the write and sets status bit 0 (active).
- R4: A command write that clears the run bit while it was set makes `stop_req` high for the cycle after the write and clears the active bit.
- R5: If the run bit was set before a command write, the direction bit (bit 3) keeps its stored value; otherwise it takes the written value. Command bits other than 0 and 3 read zero.
- R6: Host writes to status never change status bit 0 (active).
- R7: Status bits 1 (error) and 2 (interrupt) are set by `eng_err_set`/`eng_irq_set`, cleared by writing a one, and unchanged by writing a zero. When an engine set and a host clear arrive in the same cycle, the set wins. Status bits 6:5 store the written value.
- R8: The command and status registers accept only size 0. A write of any other size changes nothing and makes `bus_err` high for the cycle after.
- R9: The descriptor pointer accepts only size 2 (other sizes change nothing and pulse `bus_err`). Its bits 1:0 always read zero.
- R10: A command write that would set the run bit while the channel's `drive_present` is low leaves the command and status registers unchanged, raises no `start_req`, and pulses `bus_err` in the cycle after.
- R11: Read data is zero-extended to 32 bits. Offsets 1, 3, 5, 6 and 7 read zero, and writes to them change nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address (read and write) |
| bus_size | input | 2 | Write size code |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| drive_present | input | 2 | Per-channel drive attached |
| eng_err_set | input | 2 | Per-channel error set pulse from the engine |
| eng_irq_set | input | 2 | Per-channel interrupt set pulse from the engine |
| start_req | output | 2 | Per-channel start request pulse |
| stop_req | output | 2 | Per-channel stop request pulse |
| chan_active | output | 2 | Per-channel active flag (status bit 0) |
| chan_dir | output | 2 | Per-channel stored direction bit |
| bus_err | output | 1 | Illegal-size or refused-start pulse |

## Verification
A write is sampled at one rising edge. The register contents, `chan_active` and `chan_dir` change at that edge. `start_req`, `stop_req` and `bus_err` are high only from that edge to the next. The bench drives each write at a falling edge and compares the pulses and every register, read through the bus, with its model at the falling edge right after the sampling edge. It then checks one cycle later that all pulses have dropped again. Engine set pulses follow the same one-edge timing, and read data is compared after a short settle delay because it has no register stage.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int DATA_W = 32;
  localparam int REG_W  = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_PTR  = 2'd3
  } reg_sel_e;

  localparam int CMD_RUN  = 0;
  localparam int CMD_DIR  = 3;
  localparam int ST_ACT   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_IRQ   = 2;
  localparam int ST_CAP_L = 5;
  localparam int ST_CAP_H = 6;

  function automatic reg_sel_e offset_to_sel(input logic [2:0] off);
    case (off)
      3'd0:    return SEL_CMD;
      3'd2:    return SEL_STAT;
      3'd4:    return SEL_PTR;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic size_legal(input reg_sel_e sel, input logic [1:0] sz);
    case (sel)
      SEL_CMD, SEL_STAT: return sz == SZ_BYTE;
      SEL_PTR:           return sz == SZ_WORD;
      default:           return 1'b0;
    endcase
  endfunction

  // write-one-to-clear with engine set taking priority
  function automatic logic w1c_bit(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [DATA_W-1:0] align_dword(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NCH    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [NCH-1:0]    ch_hit,
  output reg_sel_e          sel,
  output logic              size_ok
);
  localparam int CH_W = ADDR_W - 3;

  logic [CH_W-1:0] ch_idx;
  assign ch_idx  = addr[ADDR_W-1:3];
  assign sel     = offset_to_sel(addr[2:0]);
  assign size_ok = size_legal(sel, size);

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign ch_hit[i] = (ch_idx == CH_W'(i));
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_stat,
  input  logic              wr_ptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_ok,
  input  logic              err_set,
  input  logic              irq_set,
  output logic [REG_W-1:0]  cmd_q,
  output logic [REG_W-1:0]  stat_q,
  output logic [DATA_W-1:0] ptr_q,
  output logic              start_q,
  output logic              stop_q,
  output logic              refuse_ev
);
  logic run_old, run_new;
  logic start_ev, stop_ev, cmd_take;
  logic dir_next;

  assign run_old   = cmd_q[CMD_RUN];
  assign run_new   = wdata[CMD_RUN];
  assign start_ev  = wr_cmd & ~run_old & run_new;
  assign stop_ev   = wr_cmd & run_old & ~run_new;
  assign refuse_ev = start_ev & ~drive_ok;
  assign cmd_take  = wr_cmd & ~refuse_ev;
  assign dir_next  = run_old ? cmd_q[CMD_DIR] : wdata[CMD_DIR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      stat_q  <= '0;
      ptr_q   <= '0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= start_ev & drive_ok;
      stop_q  <= stop_ev;
      if (cmd_take) begin
        cmd_q          <= '0;
        cmd_q[CMD_RUN] <= run_new;
        cmd_q[CMD_DIR] <= dir_next;
      end
      if (start_ev & drive_ok) stat_q[ST_ACT] <= 1'b1;
      else if (stop_ev)        stat_q[ST_ACT] <= 1'b0;
      stat_q[ST_ERR] <= w1c_bit(stat_q[ST_ERR], wr_stat & wdata[ST_ERR], err_set);
      stat_q[ST_IRQ] <= w1c_bit(stat_q[ST_IRQ], wr_stat & wdata[ST_IRQ], irq_set);
      if (wr_stat) stat_q[ST_CAP_H:ST_CAP_L] <= wdata[ST_CAP_H:ST_CAP_L];
      if (wr_ptr) ptr_q <= align_dword(wdata);
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    drive_present,
  input  logic [NCH-1:0]    eng_err_set,
  input  logic [NCH-1:0]    eng_irq_set,
  output logic [NCH-1:0]    start_req,
  output logic [NCH-1:0]    stop_req,
  output logic [NCH-1:0]    chan_active,
  output logic [NCH-1:0]    chan_dir,
  output logic              bus_err
);
  logic [NCH-1:0]              ch_hit;
  reg_sel_e                    sel;
  logic                        size_ok;
  logic [NCH-1:0][REG_W-1:0]   cmd_all;
  logic [NCH-1:0][REG_W-1:0]   stat_all;
  logic [NCH-1:0][DATA_W-1:0]  ptr_all;
  logic [NCH-1:0]              refuse_all;
  logic                        size_fault;
  logic                        wr_ok;

  bmdma_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .addr    (bus_addr),
    .size    (bus_size),
    .ch_hit  (ch_hit),
    .sel     (sel),
    .size_ok (size_ok)
  );

  assign wr_ok      = bus_wr & size_ok;
  assign size_fault = bus_wr & (sel != SEL_NONE) & ~size_ok & (|ch_hit);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    bmdma_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cmd    (wr_ok & ch_hit[i] & (sel == SEL_CMD)),
      .wr_stat   (wr_ok & ch_hit[i] & (sel == SEL_STAT)),
      .wr_ptr    (wr_ok & ch_hit[i] & (sel == SEL_PTR)),
      .wdata     (bus_wdata),
      .drive_ok  (drive_present[i]),
      .err_set   (eng_err_set[i]),
      .irq_set   (eng_irq_set[i]),
      .cmd_q     (cmd_all[i]),
      .stat_q    (stat_all[i]),
      .ptr_q     (ptr_all[i]),
      .start_q   (start_req[i]),
      .stop_q    (stop_req[i]),
      .refuse_ev (refuse_all[i])
    );
    assign chan_active[i] = stat_all[i][ST_ACT];
    assign chan_dir[i]    = cmd_all[i][CMD_DIR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= size_fault | (|refuse_all);
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        case (sel)
          SEL_CMD:  bus_rdata = {{(DATA_W-REG_W){1'b0}}, cmd_all[i]};
          SEL_STAT: bus_rdata = {{(DATA_W-REG_W){1'b0}}, stat_all[i]};
          SEL_PTR:  bus_rdata = ptr_all[i];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int NCH    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    drive_present,
  input logic [NCH-1:0]    start_req,
  input logic [NCH-1:0]    stop_req,
  input logic [NCH-1:0]    chan_active,
  input logic [NCH-1:0]    chan_dir,
  input logic              bus_err
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    p_start_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_req[i] |-> chan_active[i]);
    p_start_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_active[i]) |-> start_req[i]);
    p_stop_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req[i] |-> !chan_active[i]);
    p_stop_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_active[i]) |-> stop_req[i]);
    p_dir_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chan_active[i]) |-> $stable(chan_dir[i]));
    p_start_needs_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_req[i] |-> $past(drive_present[i]));
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_req[i] && stop_req[i]));
  end

  p_stat_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2:0] == 3'd2 && bus_size != 2'd0 &&
     int'(bus_addr[ADDR_W-1:3]) < NCH) |=> bus_err);
  p_ptr_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:0] == 3'd4) |-> (bus_rdata[1:0] == 2'b00));
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[0] == 1'b1 || bus_addr[2:0] == 3'd6) |-> (bus_rdata == 32'd0));
endmodule

bind bmdma_regs bmdma_regs_chk #(.ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_size      (bus_size),
  .bus_rdata     (bus_rdata),
  .drive_present (drive_present),
  .start_req     (start_req),
  .stop_req      (stop_req),
  .chan_active   (chan_active),
  .chan_dir      (chan_dir),
  .bus_err       (bus_err)
);

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  drive_present = '0;
  logic [1:0]  eng_err_set = '0;
  logic [1:0]  eng_irq_set = '0;
  logic [1:0]  start_req, stop_req, chan_active, chan_dir;
  logic        bus_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int          m_cmd [2];
  int          m_st  [2];
  logic [31:0] m_ptr [2];
  logic [1:0]  x_start, x_stop;
  logic        x_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drive_present(drive_present), .eng_err_set(eng_err_set),
    .eng_irq_set(eng_irq_set), .start_req(start_req), .stop_req(stop_req),
    .chan_active(chan_active), .chan_dir(chan_dir), .bus_err(bus_err)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int ch = 0; ch < 2; ch++) begin
      bus_addr = 4'(ch * 8 + 0); #1;
      check(bus_rdata, 32'(m_cmd[ch]), req, $sformatf("cmd ch%0d", ch));
      bus_addr = 4'(ch * 8 + 2); #1;
      check(bus_rdata, 32'(m_st[ch]), req, $sformatf("status ch%0d", ch));
      bus_addr = 4'(ch * 8 + 4); #1;
      check(bus_rdata, m_ptr[ch], req, $sformatf("pointer ch%0d", ch));
      bus_addr = 4'(ch * 8 + 6); #1;
      check(bus_rdata, 32'd0, "R11", $sformatf("unmapped ch%0d", ch));
      check(32'(chan_active[ch]), 32'(m_st[ch] & 1), req, $sformatf("active ch%0d", ch));
      check(32'(chan_dir[ch]), 32'((m_cmd[ch] >> 3) & 1), req, $sformatf("dir ch%0d", ch));
    end
  endtask

  // model of one bus cycle, computed from the requirements
  task automatic model(input int ch, input int off, input int sz, input logic [31:0] d,
                       input logic [1:0] es, input logic [1:0] is);
    x_start = '0; x_stop = '0; x_err = 0;
    if (off == 0) begin
      if (sz != 0) x_err = 1;
      else begin
        bit ro, rn, dir;
        ro = m_cmd[ch][0]; rn = d[0];
        if (!ro && rn && !drive_present[ch]) x_err = 1;
        else begin
          dir = ro ? m_cmd[ch][3] : d[3];
          if (!ro && rn) begin x_start[ch] = 1; m_st[ch] = m_st[ch] | 1; end
          if (ro && !rn) begin x_stop[ch] = 1;  m_st[ch] = m_st[ch] & ~1; end
          m_cmd[ch] = int'(rn) + (dir ? 8 : 0);
        end
      end
    end else if (off == 2) begin
      if (sz != 0) x_err = 1;
      else begin
        if (d[1]) m_st[ch] = m_st[ch] & ~2;
        if (d[2]) m_st[ch] = m_st[ch] & ~4;
        m_st[ch] = (m_st[ch] & ~32'h60) | int'(d & 32'h60);
      end
    end else if (off == 4) begin
      if (sz != 2) x_err = 1;
      else m_ptr[ch] = d & ~32'h3;
    end
    for (int c = 0; c < 2; c++) begin
      if (es[c]) m_st[c] = m_st[c] | 2;
      if (is[c]) m_st[c] = m_st[c] | 4;
    end
  endtask

  task automatic cycle(input bit wr, input int ch, input int off, input int sz,
                       input logic [31:0] d, input logic [1:0] es, input logic [1:0] is,
                       input string req);
    @(negedge clk);
    bus_wr = wr; bus_addr = 4'(ch * 8 + off); bus_size = 2'(sz); bus_wdata = d;
    eng_err_set = es; eng_irq_set = is;
    if (wr) model(ch, off, sz, d, es, is);
    else    model(ch, 7, 0, d, es, is);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; eng_err_set = '0; eng_irq_set = '0;
    check(32'(start_req), 32'(x_start), req, "start_req");
    check(32'(stop_req),  32'(x_stop),  req, "stop_req");
    check(32'(bus_err),   32'(x_err),   req, "bus_err");
    check_regs(req);
    @(posedge clk); #1;
    check(32'({start_req, stop_req, bus_err}), 32'd0, req, "pulses dropped");
  endtask

  task automatic wr(input int ch, input int off, input int sz, input logic [31:0] d, input string req);
    cycle(1, ch, off, sz, d, 2'b00, 2'b00, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_cmd[c] = 0; m_st[c] = 0; m_ptr[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(32'({start_req, stop_req, chan_active, chan_dir, bus_err}), 32'd0, "R1", "outputs after reset");
    check_regs("R1");
    rst_n = 1;
    drive_present = 2'b01;

    // R9 pointer alignment and size rule
    wr(0, 4, 2, 32'h1234_5677, "R9");
    wr(1, 4, 1, 32'hFFFF_FFFF, "R9");
    wr(1, 4, 3, 32'hFFFF_FFFF, "R9");
    // R2 channel independence
    wr(1, 4, 2, 32'hABCD_EF03, "R2");
    // R8 command size rule
    wr(0, 0, 1, 32'h0000_0009, "R8");
    // R10 start refused without drive
    wr(1, 0, 0, 32'h0000_0009, "R10");
    // R3 start with direction taken
    wr(0, 0, 0, 32'h0000_00F9, "R3");
    // R5 direction frozen while running, no second start
    wr(0, 0, 0, 32'h0000_0001, "R5");
    // R6 active bit read-only while running
    wr(0, 2, 0, 32'h0000_0000, "R6");
    // R4 stop keeps frozen direction
    wr(0, 0, 0, 32'h0000_0000, "R4");
    // R5 direction free again once stopped
    wr(0, 0, 0, 32'h0000_0000, "R5");
    // R6 active cannot be set by host
    wr(1, 2, 0, 32'h0000_0001, "R6");
    // R7 engine sets, W1C, scratch bits
    cycle(0, 0, 7, 0, 32'h0, 2'b01, 2'b01, "R7");
    wr(0, 2, 0, 32'h0000_0064, "R7");
    wr(0, 2, 0, 32'h0000_0000, "R7");
    wr(0, 2, 0, 32'h0000_0002, "R7");
    cycle(0, 0, 7, 0, 32'h0, 2'b00, 2'b01, "R7");
    cycle(1, 0, 2, 0, 32'h0000_0004, 2'b00, 2'b01, "R7");
    // R8 status size rule
    wr(0, 2, 1, 32'h0000_0004, "R8");
    wr(0, 2, 2, 32'h0000_0004, "R8");
    // R11 unmapped offsets ignored
    wr(0, 6, 0, 32'hFFFF_FFFF, "R11");
    wr(1, 1, 2, 32'hFFFF_FFFF, "R11");
    // R2 both channels running independently
    drive_present = 2'b11;
    wr(1, 0, 0, 32'h0000_0001, "R2");
    wr(0, 0, 0, 32'h0000_0009, "R3");
    wr(1, 0, 0, 32'h0000_0008, "R4");
    wr(0, 0, 0, 32'h0000_0000, "R4");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule